// File: doc/BRIEF.md
# Burst Address Generator

This block produces the word address for a synchronous burst memory. A starting address is taken from the address bus when either of two active-low load strobes is seen at a rising clock edge. One strobe belongs to the processor side and the other to the cache controller side. After the load, the low address bits step through a burst of 2^BURST_BITS words. They move one position on every clock edge where the active-low advance input is asserted. The upper address bits do not change for the whole burst.

Two step orders are available. Linear order adds the beat number to the starting low bits and wraps within the burst. Interleaved order XORs the beat number into the starting low bits. The order input is captured together with the address, so a burst keeps the order it started with.

Besides the address, the block reports the beat index and two flags, one for the first beat and one for the last. These come from a small beat-phase state machine. Its states are BEAT_FIRST, BEAT_MID and BEAT_LAST, and it has these transitions:
- load: any state goes to BEAT_FIRST.
- step: BEAT_FIRST goes to BEAT_MID, or to BEAT_LAST when the burst has only two words.
- step: BEAT_MID goes to BEAT_LAST once the count reaches its top value.
- wrap: BEAT_LAST goes back to BEAT_FIRST.
- hold: no state changes.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset is asserted (rst_n low), addr_out is 0, beat_idx is 0, beat_first is 1 and beat_last is 0.
- R2: When proc_strobe_n is low at a rising edge, addr_out equals the sampled addr_in after that edge and beat_idx is 0.
- R3: When ctrl_strobe_n is low at a rising edge, addr_out equals the sampled addr_in after that edge and beat_idx is 0.
- R4: A load has priority over advance, and the processor strobe has priority over the controller strobe. A load restarts the count at 0 even in the middle of a burst, even when adv_n is also low.
- R5: When both strobes are high and adv_n is low at a rising edge, beat_idx increases by one modulo 2^BURST_BITS.
- R6: When order_sel was 0 at the last load (linear), the low BURST_BITS bits of addr_out equal (start + beat_idx) mod 2^BURST_BITS.
- R7: When order_sel was 1 at the last load (interleaved), the low BURST_BITS bits of addr_out equal start XOR beat_idx.
- R8: Bits ADDR_W-1 down to BURST_BITS of addr_out equal those of the loaded address for the whole burst, including across a wrap.
- R9: When both strobes and adv_n are high at a rising edge, addr_out, beat_idx, beat_first and beat_last keep their values.
- R10: beat_first is 1 exactly when beat_idx is 0, and beat_last is 1 exactly when beat_idx is 2^BURST_BITS-1.
- R11: order_sel is sampled only at a load. Changing it during a burst has no effect on addr_out until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| order_sel | input | 1 | Burst order taken at load: 0 linear, 1 interleaved |
| proc_strobe_n | input | 1 | Processor address load strobe, active low |
| ctrl_strobe_n | input | 1 | Controller address load strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| addr_in | input | ADDR_W | Starting address bus |
| addr_out | output | ADDR_W | Current burst word address |
| beat_idx | output | BURST_BITS | Beat number within the burst |
| beat_first | output | 1 | High on beat 0 |
| beat_last | output | 1 | High on the final beat |

## Verification
The bench builds the block with ADDR_W = 10 and BURST_BITS = 2, which gives the four-beat burst and keeps the upper field short. With these values the bench can cover:
- starting points at every low-bit value;
- full wraps in both step orders;
- upper bits set to all-ones or to alternating patterns, which show any carry leaking out of the burst field.

A behavioural model is compared against the design on every clock. It covers:
- directed cases for strobe priority and restarts in mid-burst;
- changes of the order input in mid-burst;
- hold cycles;
- a long stretch of random stimulus.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic [1:0] {
        CMD_HOLD      = 2'd0,
        CMD_STEP      = 2'd1,
        CMD_LOAD_PROC = 2'd2,
        CMD_LOAD_CTRL = 2'd3
    } burst_cmd_e;

    typedef enum logic [1:0] {
        BEAT_FIRST = 2'd0,
        BEAT_MID   = 2'd1,
        BEAT_LAST  = 2'd2
    } beat_phase_e;

    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } burst_order_e;

    function automatic logic is_load(input burst_cmd_e c);
        return (c == CMD_LOAD_PROC) || (c == CMD_LOAD_CTRL);
    endfunction

endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
    import burst_pkg::*;
(
    input  logic       proc_strobe_n,
    input  logic       ctrl_strobe_n,
    input  logic       adv_n,
    output burst_cmd_e cmd
);

    // Load wins over advance; processor load wins over controller load.
    always_comb begin
        if (!proc_strobe_n) begin
            cmd = CMD_LOAD_PROC;
        end else if (!ctrl_strobe_n) begin
            cmd = CMD_LOAD_CTRL;
        end else if (!adv_n) begin
            cmd = CMD_STEP;
        end else begin
            cmd = CMD_HOLD;
        end
    end

endmodule

// File: rtl/burst_beat_fsm.sv
module burst_beat_fsm
    import burst_pkg::*;
#(
    parameter int BURST_BITS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  burst_cmd_e            cmd,
    output logic [BURST_BITS-1:0] beat_idx,
    output logic                  beat_first,
    output logic                  beat_last
);

    localparam logic [BURST_BITS-1:0] BEAT_MAX  = {BURST_BITS{1'b1}};
    localparam logic [BURST_BITS-1:0] BEAT_ZERO = '0;
    localparam logic [BURST_BITS-1:0] BEAT_ONE  = BURST_BITS'(1);

    beat_phase_e           phase_q, phase_d;
    logic [BURST_BITS-1:0] count_q, count_d;

    // Next-state and next-count logic.
    always_comb begin
        phase_d = phase_q;
        count_d = count_q;
        if (is_load(cmd)) begin
            phase_d = BEAT_FIRST;
            count_d = BEAT_ZERO;
        end else if (cmd == CMD_STEP) begin
            count_d = count_q + BEAT_ONE;
            unique case (phase_q)
                BEAT_FIRST: phase_d = (count_d == BEAT_MAX) ? BEAT_LAST : BEAT_MID;
                BEAT_MID:   phase_d = (count_d == BEAT_MAX) ? BEAT_LAST : BEAT_MID;
                BEAT_LAST:  phase_d = BEAT_FIRST;
                default:    phase_d = BEAT_FIRST;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= BEAT_FIRST;
            count_q <= BEAT_ZERO;
        end else begin
            phase_q <= phase_d;
            count_q <= count_d;
        end
    end

    // Outputs from state.
    always_comb begin
        beat_idx   = count_q;
        beat_first = 1'b0;
        beat_last  = 1'b0;
        unique case (phase_q)
            BEAT_FIRST: beat_first = 1'b1;
            BEAT_MID:   ;
            BEAT_LAST:  beat_last  = 1'b1;
            default:    beat_first = 1'b1;
        endcase
    end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
#(
    parameter int BURST_BITS = 2
) (
    input  logic [BURST_BITS-1:0] start_low,
    input  logic [BURST_BITS-1:0] beat,
    input  burst_order_e          order,
    output logic [BURST_BITS-1:0] low_out
);

    always_comb begin
        unique case (order)
            ORDER_LINEAR:     low_out = start_low + beat;
            ORDER_INTERLEAVE: low_out = start_low ^ beat;
            default:          low_out = start_low + beat;
        endcase
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int BURST_BITS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  order_sel,
    input  logic                  proc_strobe_n,
    input  logic                  ctrl_strobe_n,
    input  logic                  adv_n,
    input  logic [ADDR_W-1:0]     addr_in,
    output logic [ADDR_W-1:0]     addr_out,
    output logic [BURST_BITS-1:0] beat_idx,
    output logic                  beat_first,
    output logic                  beat_last
);

    localparam int UPPER_W = ADDR_W - BURST_BITS;

    burst_cmd_e            cmd;
    logic [ADDR_W-1:0]     base_q;
    burst_order_e          order_q;
    logic [BURST_BITS-1:0] low_bits;

    burst_cmd_decode u_dec (
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .adv_n         (adv_n),
        .cmd           (cmd)
    );

    burst_beat_fsm #(.BURST_BITS(BURST_BITS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .beat_idx   (beat_idx),
        .beat_first (beat_first),
        .beat_last  (beat_last)
    );

    // Start address and order are captured only on a load.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            order_q <= ORDER_LINEAR;
        end else if (is_load(cmd)) begin
            base_q  <= addr_in;
            order_q <= burst_order_e'(order_sel);
        end
    end

    burst_order_map #(.BURST_BITS(BURST_BITS)) u_map (
        .start_low (base_q[BURST_BITS-1:0]),
        .beat      (beat_idx),
        .order     (order_q),
        .low_out   (low_bits)
    );

    generate
        if (UPPER_W > 0) begin : g_upper
            assign addr_out = {base_q[ADDR_W-1:BURST_BITS], low_bits};
        end else begin : g_no_upper
            assign addr_out = low_bits;
        end
    endgenerate

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W     = 18,
    parameter int BURST_BITS = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  proc_strobe_n,
    input logic                  ctrl_strobe_n,
    input logic                  adv_n,
    input logic [ADDR_W-1:0]     addr_in,
    input logic [ADDR_W-1:0]     addr_out,
    input logic [BURST_BITS-1:0] beat_idx,
    input logic                  beat_first,
    input logic                  beat_last
);

    localparam logic [BURST_BITS-1:0] TOP = {BURST_BITS{1'b1}};

    logic strobe_any;
    assign strobe_any = !proc_strobe_n || !ctrl_strobe_n;

    // R2 R3 R4: any strobe loads the bus and restarts at beat 0
    a_r4_load_restart: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_any |=> (beat_idx == '0) && (addr_out == $past(addr_in)));

    // R5: advance without strobe steps the beat
    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_any && !adv_n) |=> beat_idx == BURST_BITS'($past(beat_idx) + 1'b1));

    // R9: idle cycle holds everything
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_any && adv_n) |=> ($stable(addr_out) && $stable(beat_idx)
                                    && $stable(beat_first) && $stable(beat_last)));

    // R8: upper bits fixed while no load
    a_r8_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_any |=> $stable(addr_out[ADDR_W-1:BURST_BITS]));

    // R10: flags agree with the beat counter
    a_r10_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_first == (beat_idx == '0)) && (beat_last == (beat_idx == TOP)));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(
    .ADDR_W     (ADDR_W),
    .BURST_BITS (BURST_BITS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .adv_n         (adv_n),
    .addr_in       (addr_in),
    .addr_out      (addr_out),
    .beat_idx      (beat_idx),
    .beat_first    (beat_first),
    .beat_last     (beat_last)
);

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;

    localparam int AW = 10;
    localparam int BB = 2;
    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          order_sel = 1'b0;
    logic          proc_strobe_n = 1'b1;
    logic          ctrl_strobe_n = 1'b1;
    logic          adv_n = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic [BB-1:0] beat_idx;
    logic          beat_first;
    logic          beat_last;

    int vectors = 0;
    int fails   = 0;

    int m_base = 0;
    int m_beat = 0;
    int m_mode = 0;

    always #10 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW), .BURST_BITS(BB)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .order_sel     (order_sel),
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .adv_n         (adv_n),
        .addr_in       (addr_in),
        .addr_out      (addr_out),
        .beat_idx      (beat_idx),
        .beat_first    (beat_first),
        .beat_last     (beat_last)
    );

    function automatic int exp_addr();
        int lo = m_base % NB;
        int ex_lo = (m_mode != 0) ? (lo ^ m_beat) : ((lo + m_beat) % NB);
        return (m_base - lo) + ex_lo;
    endfunction

    task automatic compare(input string tag);
        int ea = exp_addr();
        vectors++;
        if (int'(addr_out) != ea || int'(beat_idx) != m_beat ||
            beat_first != (m_beat == 0) || beat_last != (m_beat == NB-1)) begin
            fails++;
            $display("FAIL %s: addr=%0h beat=%0d first=%0b last=%0b expected addr=%0h beat=%0d first=%0b last=%0b",
                     tag, addr_out, beat_idx, beat_first, beat_last,
                     ea, m_beat, (m_beat == 0), (m_beat == NB-1));
        end
    endtask

    task automatic cyc(input logic p, input logic c, input logic a,
                       input int ad, input logic md, input string tag);
        proc_strobe_n = p;
        ctrl_strobe_n = c;
        adv_n         = a;
        addr_in       = AW'(ad);
        order_sel     = md;
        @(posedge clk);
        if (!p || !c) begin
            m_base = ad % (1 << AW);
            m_beat = 0;
            m_mode = md;
        end else if (!a) begin
            m_beat = (m_beat + 1) % NB;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: run did not complete, expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after release");

        // R2 processor load, linear order, full wrap (R5 R6 R8 R10)
        cyc(0, 1, 1, 'h1A6, 0, "R2 proc load");
        for (int i = 0; i < 5; i++) cyc(1, 1, 0, 'h3FF, 1, "R6 linear step R8");
        // R9 hold
        for (int i = 0; i < 3; i++) cyc(1, 1, 1, 'h055, 1, "R9 hold");

        // R3 controller load, interleaved order (R7)
        cyc(1, 0, 1, 'h3F1, 1, "R3 ctrl load");
        for (int i = 0; i < 5; i++) cyc(1, 1, 0, 'h000, 0, "R7 interleave step R11");

        // R4 mid-burst restart with advance also asserted
        cyc(1, 1, 0, 'h000, 0, "R5 step");
        cyc(1, 0, 0, 'h2AB, 0, "R4 restart over advance");
        cyc(1, 1, 0, 'h000, 1, "R11 mode change ignored");
        cyc(0, 0, 0, 'h156, 1, "R4 both strobes");
        for (int i = 0; i < 4; i++) cyc(1, 1, 0, 'h3FF, 0, "R11 order kept R7");

        // boundary: start at every low value in both orders
        for (int s = 0; s < NB; s++) begin
            for (int md = 0; md < 2; md++) begin
                cyc(0, 1, 1, 'h3FC + s, md[0], "R6 R7 start sweep");
                for (int k = 0; k < NB; k++) cyc(1, 1, 0, 0, 0, "R8 sweep step");
            end
        end

        for (int i = 0; i < 400; i++) begin
            int r = $urandom % 16;
            cyc(r < 2 ? 1'b0 : 1'b1, (r == 1 || r == 2 || r == 3) ? 1'b0 : 1'b1,
                r[0], $urandom % (1 << AW), r[1], "R5 R6 R7 R9 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule